// File: doc/BRIEF.md
# Hardware Cursor Register File and Pixel Classifier

This block keeps the programming state of a hardware graphics cursor and presents it, already decoded, to the cursor overlay logic. Software reaches it through a small indexed byte port. An index, a write strobe and a read strobe select one of twelve byte-wide registers. The block drives the state held in those registers as wide parallel outputs. These outputs are the cursor enable, the 11-bit horizontal and vertical origin, the 16-bit storage base (in 1 KiB units), the two 6-bit pattern start offsets, and both four-entry colour stacks.

The foreground and background colours are written through one index each. Each of those indices acts as a small stack with its own pointer. A write stores the byte at the pointer and advances the pointer, wrapping after four entries. A read returns the entry at the pointer and sends the pointer back to entry 0. The cursor bitmap has two bits per pixel, A and B. It is kept in memory as a 16-bit word of A bits followed by a 16-bit word of B bits. The fetch logic outside this block passes each pixel's A and B bits in. The block answers with a 2-bit selection code: background, foreground, screen, or inverted screen. Which mapping applies is set by a mode bit in the DAC control register. The final colour is computed downstream.

Top module: `hwcur_regs`

## Requirements
- R1: After a synchronous reset all four foreground stack entries are 0xFF, all four background entries are 0x00, every other register is 0, both stack pointers are 0, `reg_rdata` is 0x00 and `pix_sel` is 0.
- R2: A write to index 0x5 (foreground) stores the byte in the entry at the foreground pointer, then advances that pointer modulo 4. Entry k appears on `fg_stack[8k+7:8k]`. No other index changes `fg_stack`.
- R3: A write to index 0x6 (background) behaves in the same way, using its own pointer, on `bg_stack`.
- R4: A read of index 0x5 or 0x6 returns the entry at that stack's current pointer, then resets that pointer to 0. The other stack's pointer is not changed.
- R5: The X origin high/low bytes are at index 0x1/0x2, and the Y origin high/low bytes are at 0x3/0x4. A write to one half leaves the other half unchanged. Only bits 2:0 of a high byte are kept, so `cur_x`/`cur_y` are 11 bits wide and a high-byte readback has bits 7:3 zero.
- R6: The storage base high/low bytes are at index 0x7/0x8. They form `cur_base[15:8]`/`cur_base[7:0]`, and each half updates alone.
- R7: Index 0x0 is the mode byte, and `cur_en` equals its bit 0. Indices 0x9/0xA hold the pattern start X/Y and keep only bits 5:0, which also read back with bits 7:6 zero.
- R8: With bit 4 of the DAC control byte (index 0xB) clear, AB pixel codes map as follows: 00 to background (0), 01 to foreground (1), 10 to screen (2), 11 to inverted screen (3). `pix_sel` is registered and shows the code one cycle after A and B are applied.
- R9: With bit 4 of index 0xB set, AB codes map as follows: 00 and 01 to screen (2), 10 to background (0), 11 to foreground (1). All other bits of index 0xB have no effect on the mapping.
- R10: `reg_rdata` is loaded on the edge that samples `reg_re`, and it holds its value in any cycle without a read. A read of an unmapped index (0xC to 0xF) returns 0x00. A write to an unmapped index changes no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_idx | input | 4 | Register index |
| reg_wdata | input | 8 | Write data |
| reg_we | input | 1 | Write strobe |
| reg_re | input | 1 | Read strobe |
| reg_rdata | output | 8 | Registered read data |
| cur_en | output | 1 | Cursor enable |
| cur_x | output | 11 | Cursor X origin |
| cur_y | output | 11 | Cursor Y origin |
| cur_base | output | 16 | Bitmap storage base, 1 KiB units |
| pat_x | output | 6 | Pattern start X offset |
| pat_y | output | 6 | Pattern start Y offset |
| fg_stack | output | 32 | Foreground entries 0..3, entry 0 in the low byte |
| bg_stack | output | 32 | Background entries 0..3, entry 0 in the low byte |
| pix_a | input | 1 | Cursor bitmap A bit of the current pixel |
| pix_b | input | 1 | Cursor bitmap B bit of the current pixel |
| pix_sel | output | 2 | Pixel selection code |

## Verification
The stack pointers are not visible on any port. A pointer that is wrong shows up only on the next stack access. The next write lands in the wrong byte of `fg_stack` or `bg_stack` one cycle later, or the next read returns the wrong entry. For that reason the stack sequences interleave writes, reads and wraparound before checking either bus. A half-register write that spills into its neighbour, or a high-byte mask that is wrong, appears on the origin and base buses on the cycle after the write. A wrong mode bit or a wrong mapping appears on `pix_sel` one cycle after the AB bits are applied.

// File: rtl/hwcur_pkg.sv
package hwcur_pkg;
  localparam int IDX_W = 4;
  typedef logic [IDX_W-1:0] idx_t;

  localparam idx_t IDX_MODE = 4'h0;
  localparam idx_t IDX_XHI  = 4'h1;
  localparam idx_t IDX_XLO  = 4'h2;
  localparam idx_t IDX_YHI  = 4'h3;
  localparam idx_t IDX_YLO  = 4'h4;
  localparam idx_t IDX_FG   = 4'h5;
  localparam idx_t IDX_BG   = 4'h6;
  localparam idx_t IDX_BHI  = 4'h7;
  localparam idx_t IDX_BLO  = 4'h8;
  localparam idx_t IDX_PATX = 4'h9;
  localparam idx_t IDX_PATY = 4'hA;
  localparam idx_t IDX_DAC  = 4'hB;

  localparam int X11_BIT = 4;

  typedef enum logic [1:0] {
    SEL_BG     = 2'd0,
    SEL_FG     = 2'd1,
    SEL_SCREEN = 2'd2,
    SEL_INVERT = 2'd3
  } pix_sel_e;
endpackage

// File: rtl/hwcur_stack.sv
module hwcur_stack #(
  parameter int DEPTH = 4,
  parameter logic [7:0] RST_VAL = 8'h00,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 we,
  input  logic                 re,
  input  logic [7:0]           wdata,
  output logic [7:0]           top_entry,
  output logic [DEPTH*8-1:0]   flat
);
  logic [7:0]       mem [DEPTH];
  logic [PTR_W-1:0] ptr;

  assign top_entry = mem[ptr];

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr <= '0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= RST_VAL;
    end else if (we) begin
      mem[ptr] <= wdata;
      ptr <= (ptr == PTR_W'(DEPTH - 1)) ? '0 : ptr + 1'b1;
    end else if (re) begin
      ptr <= '0;
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_flat
    assign flat[g*8 +: 8] = mem[g];
  end
endmodule

// File: rtl/hwcur_pair.sv
module hwcur_pair #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         we_hi,
  input  logic         we_lo,
  input  logic [7:0]   wdata,
  output logic [W-1:0] q,
  output logic [7:0]   rd_hi,
  output logic [7:0]   rd_lo
);
  always_ff @(posedge clk) begin
    if (rst) begin
      q <= '0;
    end else if (we_hi) begin
      q <= W'({wdata, q[7:0]});
    end else if (we_lo) begin
      q <= W'({q >> 8, wdata});
    end
  end

  assign rd_hi = 8'(q >> 8);
  assign rd_lo = q[7:0];
endmodule

// File: rtl/hwcur_pixdec.sv
module hwcur_pixdec
  import hwcur_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       x11,
  input  logic       a,
  input  logic       b,
  output logic [1:0] sel
);
  pix_sel_e nxt;

  always_comb begin
    if (x11) begin
      unique case ({a, b})
        2'b10:   nxt = SEL_BG;
        2'b11:   nxt = SEL_FG;
        default: nxt = SEL_SCREEN;
      endcase
    end else begin
      unique case ({a, b})
        2'b00:   nxt = SEL_BG;
        2'b01:   nxt = SEL_FG;
        2'b10:   nxt = SEL_SCREEN;
        default: nxt = SEL_INVERT;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) sel <= SEL_BG;
    else     sel <= nxt;
  end
endmodule

// File: rtl/hwcur_regs.sv
module hwcur_regs
  import hwcur_pkg::*;
#(
  parameter int POS_W  = 11,
  parameter int BASE_W = 16,
  parameter int PAT_W  = 6,
  parameter int DEPTH  = 4,
  localparam int STK_W = DEPTH * 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [IDX_W-1:0]  reg_idx,
  input  logic [7:0]        reg_wdata,
  input  logic              reg_we,
  input  logic              reg_re,
  output logic [7:0]        reg_rdata,
  output logic              cur_en,
  output logic [POS_W-1:0]  cur_x,
  output logic [POS_W-1:0]  cur_y,
  output logic [BASE_W-1:0] cur_base,
  output logic [PAT_W-1:0]  pat_x,
  output logic [PAT_W-1:0]  pat_y,
  output logic [STK_W-1:0]  fg_stack,
  output logic [STK_W-1:0]  bg_stack,
  input  logic              pix_a,
  input  logic              pix_b,
  output logic [1:0]        pix_sel
);
  logic [7:0] mode_q, dac_q;
  logic [7:0] fg_top, bg_top;
  logic [7:0] xh, xl, yh, yl, bh, bl;
  logic       x11_mode;
  logic [7:0] rd_mux;

  function automatic logic hit(input idx_t i);
    return reg_we && (reg_idx == i);
  endfunction

  assign x11_mode = dac_q[X11_BIT];
  assign cur_en   = mode_q[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= '0;
      dac_q  <= '0;
      pat_x  <= '0;
      pat_y  <= '0;
    end else begin
      if (hit(IDX_MODE)) mode_q <= reg_wdata;
      if (hit(IDX_DAC))  dac_q  <= reg_wdata;
      if (hit(IDX_PATX)) pat_x  <= PAT_W'(reg_wdata);
      if (hit(IDX_PATY)) pat_y  <= PAT_W'(reg_wdata);
    end
  end

  hwcur_pair #(.W(POS_W)) u_xpos (
    .clk(clk), .rst(rst), .we_hi(hit(IDX_XHI)), .we_lo(hit(IDX_XLO)),
    .wdata(reg_wdata), .q(cur_x), .rd_hi(xh), .rd_lo(xl));

  hwcur_pair #(.W(POS_W)) u_ypos (
    .clk(clk), .rst(rst), .we_hi(hit(IDX_YHI)), .we_lo(hit(IDX_YLO)),
    .wdata(reg_wdata), .q(cur_y), .rd_hi(yh), .rd_lo(yl));

  hwcur_pair #(.W(BASE_W)) u_base (
    .clk(clk), .rst(rst), .we_hi(hit(IDX_BHI)), .we_lo(hit(IDX_BLO)),
    .wdata(reg_wdata), .q(cur_base), .rd_hi(bh), .rd_lo(bl));

  hwcur_stack #(.DEPTH(DEPTH), .RST_VAL(8'hFF)) u_fg (
    .clk(clk), .rst(rst), .we(hit(IDX_FG)),
    .re(reg_re && reg_idx == IDX_FG), .wdata(reg_wdata),
    .top_entry(fg_top), .flat(fg_stack));

  hwcur_stack #(.DEPTH(DEPTH), .RST_VAL(8'h00)) u_bg (
    .clk(clk), .rst(rst), .we(hit(IDX_BG)),
    .re(reg_re && reg_idx == IDX_BG), .wdata(reg_wdata),
    .top_entry(bg_top), .flat(bg_stack));

  hwcur_pixdec u_dec (
    .clk(clk), .rst(rst), .x11(x11_mode), .a(pix_a), .b(pix_b), .sel(pix_sel));

  always_comb begin
    unique case (reg_idx)
      IDX_MODE: rd_mux = mode_q;
      IDX_XHI:  rd_mux = xh;
      IDX_XLO:  rd_mux = xl;
      IDX_YHI:  rd_mux = yh;
      IDX_YLO:  rd_mux = yl;
      IDX_FG:   rd_mux = fg_top;
      IDX_BG:   rd_mux = bg_top;
      IDX_BHI:  rd_mux = bh;
      IDX_BLO:  rd_mux = bl;
      IDX_PATX: rd_mux = 8'(pat_x);
      IDX_PATY: rd_mux = 8'(pat_y);
      IDX_DAC:  rd_mux = dac_q;
      default:  rd_mux = 8'h00;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)         reg_rdata <= 8'h00;
    else if (reg_re) reg_rdata <= rd_mux;
  end
endmodule

// File: rtl/hwcur_regs_chk.sv
module hwcur_regs_chk
  import hwcur_pkg::*;
#(
  parameter int POS_W = 11,
  parameter int STK_W = 32
) (
  input logic             clk,
  input logic             rst,
  input logic [IDX_W-1:0] reg_idx,
  input logic [7:0]       reg_wdata,
  input logic             reg_we,
  input logic             reg_re,
  input logic [7:0]       reg_rdata,
  input logic             cur_en,
  input logic [POS_W-1:0] cur_x,
  input logic [STK_W-1:0] fg_stack,
  input logic             pix_a,
  input logic             pix_b,
  input logic [1:0]       pix_sel,
  input logic             x11_mode
);
  // R2
  fg_untouched_chk: assert property (@(posedge clk) disable iff (rst)
    !(reg_we && reg_idx == IDX_FG) |=> $stable(fg_stack));

  // R5
  xlo_keeps_hi_chk: assert property (@(posedge clk) disable iff (rst)
    (reg_we && reg_idx == IDX_XLO) |=> cur_x[POS_W-1:8] == $past(cur_x[POS_W-1:8]));

  // R7
  enable_bit_chk: assert property (@(posedge clk) disable iff (rst)
    (reg_we && reg_idx == IDX_MODE) |=> cur_en == $past(reg_wdata[0]));

  // R8
  win_fg_code_chk: assert property (@(posedge clk) disable iff (rst)
    (!x11_mode && !pix_a && pix_b) |=> pix_sel == 2'd1);

  // R9
  x11_screen_code_chk: assert property (@(posedge clk) disable iff (rst)
    (x11_mode && !pix_a) |=> pix_sel == 2'd2);

  // R10
  rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !reg_re |=> $stable(reg_rdata));
endmodule

bind hwcur_regs hwcur_regs_chk #(.POS_W(POS_W), .STK_W(STK_W)) u_chk (
  .clk(clk), .rst(rst), .reg_idx(reg_idx), .reg_wdata(reg_wdata),
  .reg_we(reg_we), .reg_re(reg_re), .reg_rdata(reg_rdata), .cur_en(cur_en),
  .cur_x(cur_x), .fg_stack(fg_stack), .pix_a(pix_a), .pix_b(pix_b),
  .pix_sel(pix_sel), .x11_mode(x11_mode));

// File: tb/hwcur_regs_bench.sv
module hwcur_regs_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 26;

  // op: 1 = write, 2 = read and compare; fields {op, idx, data, expected}
  localparam logic [21:0] VEC [NVEC] = '{
    {2'd1, 4'h1, 8'hFD, 8'h00}, {2'd1, 4'h2, 8'h34, 8'h00},
    {2'd2, 4'h1, 8'h00, 8'h05}, {2'd2, 4'h2, 8'h00, 8'h34},
    {2'd1, 4'h2, 8'h99, 8'h00}, {2'd2, 4'h1, 8'h00, 8'h05},
    {2'd2, 4'h2, 8'h00, 8'h99}, {2'd1, 4'h3, 8'h07, 8'h00},
    {2'd1, 4'h4, 8'hFF, 8'h00}, {2'd2, 4'h3, 8'h00, 8'h07},
    {2'd2, 4'h4, 8'h00, 8'hFF}, {2'd1, 4'h7, 8'hAB, 8'h00},
    {2'd1, 4'h8, 8'hCD, 8'h00}, {2'd2, 4'h7, 8'h00, 8'hAB},
    {2'd2, 4'h8, 8'h00, 8'hCD}, {2'd1, 4'h9, 8'hFF, 8'h00},
    {2'd2, 4'h9, 8'h00, 8'h3F}, {2'd1, 4'hA, 8'h41, 8'h00},
    {2'd2, 4'hA, 8'h00, 8'h01}, {2'd1, 4'h0, 8'h81, 8'h00},
    {2'd2, 4'h0, 8'h00, 8'h81}, {2'd2, 4'hF, 8'h00, 8'h00},
    {2'd1, 4'hF, 8'h55, 8'h00}, {2'd1, 4'hC, 8'h5A, 8'h00},
    {2'd2, 4'hF, 8'h00, 8'h00}, {2'd2, 4'hC, 8'h00, 8'h00}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  reg_idx = '0;
  logic [7:0]  reg_wdata = '0;
  logic        reg_we = 1'b0, reg_re = 1'b0;
  logic [7:0]  reg_rdata;
  logic        cur_en;
  logic [10:0] cur_x, cur_y;
  logic [15:0] cur_base;
  logic [5:0]  pat_x, pat_y;
  logic [31:0] fg_stack, bg_stack;
  logic        pix_a = 1'b0, pix_b = 1'b0;
  logic [1:0]  pix_sel;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hwcur_regs u_hwcur_regs (
    .clk(clk), .rst(rst), .reg_idx(reg_idx), .reg_wdata(reg_wdata),
    .reg_we(reg_we), .reg_re(reg_re), .reg_rdata(reg_rdata), .cur_en(cur_en),
    .cur_x(cur_x), .cur_y(cur_y), .cur_base(cur_base), .pat_x(pat_x),
    .pat_y(pat_y), .fg_stack(fg_stack), .bg_stack(bg_stack),
    .pix_a(pix_a), .pix_b(pix_b), .pix_sel(pix_sel));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] idx, input logic [7:0] d);
    reg_idx = idx; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] idx, output logic [7:0] d);
    reg_idx = idx; reg_re = 1'b1;
    @(negedge clk);
    reg_re = 1'b0;
    d = reg_rdata;
  endtask

  function automatic logic [1:0] exp_sel(input logic x11, input logic a, input logic b);
    if (x11) return a ? (b ? 2'd1 : 2'd0) : 2'd2;
    return {a, b};
  endfunction

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] r;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    check("R1 fg_stack", fg_stack, 32'hFFFF_FFFF);
    check("R1 bg_stack", bg_stack, 32'h0);
    check("R1 position", {cur_x, cur_y, cur_base}, 38'h0);
    check("R1 misc", {cur_en, pat_x, pat_y, pix_sel, reg_rdata}, 0);

    // R5 R6 R7 R10 table walk
    for (int i = 0; i < NVEC; i++) begin
      if (VEC[i][21:20] == 2'd1) wr(VEC[i][19:16], VEC[i][15:8]);
      else begin
        rd(VEC[i][19:16], r);
        check($sformatf("R5/R6/R7/R10 readback vec%0d", i), r, VEC[i][7:0]);
      end
    end
    check("R5 cur_x", cur_x, 11'h599);
    check("R5 cur_y", cur_y, 11'h7FF);
    check("R6 cur_base", cur_base, 16'hABCD);
    check("R7 pat", {pat_x, pat_y}, {6'h3F, 6'h01});
    check("R7 cur_en", cur_en, 1'b1);
    wr(4'h0, 8'hFE);
    check("R7 cur_en clear", cur_en, 1'b0);

    // R10 hold without read
    rd(4'h7, r);
    @(negedge clk); @(negedge clk);
    check("R10 rdata hold", reg_rdata, 8'hAB);

    // R2 R4 foreground stack
    wr(4'h5, 8'h11); wr(4'h5, 8'h22);
    check("R2 fg two writes", fg_stack, 32'hFFFF_2211);
    rd(4'h5, r);
    check("R4 fg read at ptr", r, 8'hFF);
    wr(4'h5, 8'h33);
    check("R4 fg ptr reset", fg_stack, 32'hFFFF_2233);
    wr(4'h5, 8'h44); wr(4'h5, 8'h55); wr(4'h5, 8'h66); wr(4'h5, 8'h77);
    check("R2 fg wrap", fg_stack, 32'h6655_4477);
    rd(4'h5, r);
    check("R4 fg read entry1", r, 8'h44);
    rd(4'h5, r);
    check("R4 fg reread entry0", r, 8'h77);

    // R3 R4 background stack
    rd(4'h6, r);
    check("R4 bg read reset entry", r, 8'h00);
    wr(4'h6, 8'hA1);
    check("R3 bg first write", bg_stack, 32'h0000_00A1);
    wr(4'h6, 8'hA2); wr(4'h6, 8'hA3); wr(4'h6, 8'hA4); wr(4'h6, 8'hA5);
    check("R3 bg wrap", bg_stack, 32'hA4A3_A2A5);
    check("R2 fg untouched by bg", fg_stack, 32'h6655_4477);
    rd(4'h6, r);
    check("R4 bg read at ptr", r, 8'hA2);
    wr(4'h6, 8'hB0);
    check("R4 bg ptr reset", bg_stack, 32'hA4A3_A2B0);

    // R8 R9 pixel decode, two DAC settings per mode
    for (int m = 0; m < 4; m++) begin
      logic [7:0] dac;
      dac = (m == 0) ? 8'h00 : (m == 1) ? 8'hEF : (m == 2) ? 8'h10 : 8'hFF;
      wr(4'hB, dac);
      for (int c = 0; c < 4; c++) begin
        pix_a = c[1]; pix_b = c[0];
        @(negedge clk);
        check(dac[4] ? "R9 x11 decode" : "R8 windows decode",
              pix_sel, exp_sel(dac[4], c[1], c[0]));
      end
    end

    // R1 reset again
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R1 re-reset stacks", {fg_stack, bg_stack}, {32'hFFFF_FFFF, 32'h0});
    rd(4'h5, r);
    check("R1 fg ptr zero", r, 8'hFF);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule